// File: doc/BRIEF.md
# Serial Clock Wait-State Controller

This block inserts wait states on the clock line of a two-wire serial bus, byte by byte. It samples the shared clock line through a synchronizer and counts rising edges while a transfer is in progress. When the count reaches a software-selected point it issues a one-cycle interrupt request to the byte engine's software. In the holding modes it also pulls the clock line low so that the other end of the bus stalls.

Software resumes the bus by writing a release bit. That bit clears itself as soon as the wait has ended, and the edge count restarts for the next byte. The same behaviour serves both roles. A master stops after it has produced the selected number of clocks. A slave stalls the master after it has received that number.

Between transfers, a configuration bit sets the clock line's resting level: pulled low, or released so the pull-up takes it high, as a master needs when forming start and stop conditions. The clock line is only ever pulled low, never driven high. The block also flags a configuration error when a non-holding wait mode is written while the bus mode is enabled.

Top module: `scl_wait_ctrl`

## Requirements
- R1: After reset the readback is 0x00, `irqPulse` and `cfgError` are low, and with no transfer active `sclPullLow` is high.
- R2: The control word occupies bits [1:0] of the write port. Selector 2'b10 counts 8 rising clock edges and 2'b11 counts 9. The interrupt is raised for the rising edge at which that count is reached, three system clocks after `sclIn` rises: two synchronizer stages and one output register.
- R3: With selector bit 1 set, `sclPullLow` goes high in the same cycle as the interrupt and stays high until the wait is released, whether or not a transfer is active.
- R4: With selector 2'b00 or 2'b01, the interrupt is raised at the 8th edge and the clock line is not held. The count then restarts, so the next interrupt comes 8 edges later.
- R5: Writing 1 to bit 2 while waiting ends the wait within two system clocks. Bit 2 then reads back 0.
- R6: After a release the edge count starts from zero, so the next interrupt again needs the full 8 or 9 edges.
- R7: Rising clock edges seen while waiting neither raise an interrupt nor advance the count.
- R8: With no transfer active and no wait pending, bit 3 set to 0 makes `sclPullLow` high, and set to 1 makes it low.
- R9: Bit 4 reads back the synchronized clock-line level and ignores writes.
- R10: A write with `i2cMode` high and bit 1 of the written value equal to 0 sets `cfgError`, which also reads back on bit 5. Any write that does not meet that condition clears it.
- R11: `irqPulse` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Control register write strobe |
| regWrData | input | 8 | Control register write value |
| regRdData | output | 8 | Control register readback |
| i2cMode | input | 1 | Bus mode enabled (used for the configuration check) |
| xferActive | input | 1 | A byte transfer is in progress |
| sclIn | input | 1 | Clock line as seen at the pin |
| sclPullLow | output | 1 | Open-drain pull-low enable for the clock line |
| irqPulse | output | 1 | One-cycle interrupt request |
| cfgError | output | 1 | Invalid wait selector written in bus mode |

## Verification
The bench sweeps all four selector codes and checks two things on each: the exact edge on which the interrupt lands, and whether the line is held. A counter that is off by one, or that decodes 2'b11 as 8, moves the interrupt to the wrong pulse. A design that keeps counting during a wait, or that does not clear the count on release, fires early or spuriously. The bench also covers a self-clearing bit that sticks or never releases the line, the idle level when its polarity is inverted, a read-only bit that latches write data, and the error flag across every combination of mode and selector.

// File: rtl/scl_wait_pkg.sv
package scl_wait_pkg;

  localparam int SEL_W = 2;

  // readback / write bit positions
  localparam int BIT_REL   = 2;
  localparam int BIT_IDLE  = 3;
  localparam int BIT_LEVEL = 4;
  localparam int BIT_ERR   = 5;
  localparam int USED_BITS = 6;

  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } waitState_t;

  // control -> datapath
  typedef struct packed {
    logic cntInc;
    logic cntClr;
    logic irqSet;
    logic relClr;
  } ctrlStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic riseDet;
    logic cntHit;
    logic holdEn;
    logic relReq;
  } pathStatus_t;

endpackage

// File: rtl/scl_wait_ctrl_path.sv
module scl_wait_ctrl_path
  import scl_wait_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_CNT   = 8,
  parameter int LONG_CNT    = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             i2cMode,
  input  logic             xferActive,
  input  logic             sclIn,
  input  ctrlStrobe_t      strobe,
  input  logic             waitActive,
  output pathStatus_t      status,
  output logic             sclPullLow,
  output logic             irqPulse,
  output logic             cfgError
);

  localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_CNT);
  localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_CNT);
  localparam int PAD_W = REG_W - USED_BITS;

  // clock-line synchronizer
  logic [SYNC_STAGES-1:0] syncQ;
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : gSync
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= sclIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[g] <= 1'b0;
        else       syncQ[g] <= syncQ[g-1];
      end
    end
  end

  logic sclLevel;
  logic sclPrev;
  assign sclLevel = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sclPrev <= 1'b0;
    else       sclPrev <= sclLevel;
  end

  // control register fields
  logic [SEL_W-1:0] waitSelQ;
  logic             relQ;
  logic             idleRelQ;
  logic             errQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitSelQ <= '0;
      idleRelQ <= 1'b0;
      errQ     <= 1'b0;
    end else if (regWrEn) begin
      waitSelQ <= regWrData[SEL_W-1:0];
      idleRelQ <= regWrData[BIT_IDLE];
      errQ     <= i2cMode & ~regWrData[1];
    end
  end

  // self-clearing release request; a new write of 1 wins over the clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            relQ <= 1'b0;
    else if (regWrEn && regWrData[BIT_REL]) relQ <= 1'b1;
    else if (strobe.relClr)               relQ <= 1'b0;
  end

  // edge counter
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W-1:0] target;

  assign cntNext = cntQ + CNT_W'(1);
  assign target  = (waitSelQ == 2'b11) ? LONG_V : SHORT_V;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cntQ <= '0;
    else if (strobe.cntClr) cntQ <= '0;
    else if (strobe.cntInc) cntQ <= cntNext;
  end

  // interrupt register
  logic irqQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= 1'b0;
    else       irqQ <= strobe.irqSet;
  end

  always_comb begin
    status.riseDet = sclLevel & ~sclPrev;
    status.cntHit  = status.riseDet && (cntNext == target);
    status.holdEn  = waitSelQ[1];
    status.relReq  = relQ;
  end

  assign sclPullLow = waitActive | (~xferActive & ~idleRelQ);
  assign irqPulse   = irqQ;
  assign cfgError   = errQ;

  logic [USED_BITS-1:0] rdCore;
  assign rdCore = {errQ, sclLevel, idleRelQ, relQ, waitSelQ};

  if (PAD_W > 0) begin : gPad
    assign regRdData = {{PAD_W{1'b0}}, rdCore};
    logic unusedWrBits;
    assign unusedWrBits = ^regWrData[REG_W-1:BIT_LEVEL];
  end else begin : gNoPad
    assign regRdData = rdCore[REG_W-1:0];
    logic unusedWrBits;
    assign unusedWrBits = regWrData[BIT_LEVEL];
  end

endmodule

// File: rtl/scl_wait_ctrl_fsm.sv
module scl_wait_ctrl_fsm
  import scl_wait_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        xferActive,
  input  pathStatus_t status,
  output ctrlStrobe_t strobe,
  output logic        waitActive
);

  waitState_t stateQ;
  waitState_t stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_RUN;
    else       stateQ <= stateNext;
  end

  always_comb begin
    stateNext = stateQ;
    strobe    = '0;
    unique case (stateQ)
      ST_RUN: begin
        if (!xferActive) begin
          strobe.cntClr = 1'b1;
        end else if (status.cntHit) begin
          strobe.irqSet = 1'b1;
          if (status.holdEn) begin
            stateNext = ST_WAIT;       // count frozen during the wait
          end else begin
            strobe.cntClr = 1'b1;      // non-holding: restart the byte
          end
        end else if (status.riseDet) begin
          strobe.cntInc = 1'b1;
        end
      end
      ST_WAIT: begin
        if (status.relReq) begin
          stateNext     = ST_RUN;
          strobe.cntClr = 1'b1;
          strobe.relClr = 1'b1;
        end
      end
      default: stateNext = ST_RUN;
    endcase
  end

  assign waitActive = (stateQ == ST_WAIT);

endmodule

// File: rtl/scl_wait_ctrl.sv
module scl_wait_ctrl
  import scl_wait_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_CNT   = 8,
  parameter int LONG_CNT    = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             i2cMode,
  input  logic             xferActive,
  input  logic             sclIn,
  output logic             sclPullLow,
  output logic             irqPulse,
  output logic             cfgError
);

  ctrlStrobe_t strobe;
  pathStatus_t status;
  logic        waitActive;

  scl_wait_ctrl_path #(
    .REG_W      (REG_W),
    .CNT_W      (CNT_W),
    .SYNC_STAGES(SYNC_STAGES),
    .SHORT_CNT  (SHORT_CNT),
    .LONG_CNT   (LONG_CNT)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .i2cMode   (i2cMode),
    .xferActive(xferActive),
    .sclIn     (sclIn),
    .strobe    (strobe),
    .waitActive(waitActive),
    .status    (status),
    .sclPullLow(sclPullLow),
    .irqPulse  (irqPulse),
    .cfgError  (cfgError)
  );

  scl_wait_ctrl_fsm u_fsm (
    .clk       (clk),
    .rstN      (rstN),
    .xferActive(xferActive),
    .status    (status),
    .strobe    (strobe),
    .waitActive(waitActive)
  );

endmodule

// File: rtl/scl_wait_ctrl_chk.sv
module scl_wait_ctrl_chk #(
  parameter int REG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic             i2cMode,
  input logic             xferActive,
  input logic             sclPullLow,
  input logic             irqPulse,
  input logic             cfgError,
  input logic             waitActive
);

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse); // R11

  AST_HOLD_AT_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && regRdData[1]) |-> sclPullLow); // R3

  AST_WAIT_PULLS: assert property (@(posedge clk) disable iff (!rstN)
    waitActive |-> sclPullLow); // R3

  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && !regRdData[3]) |-> sclPullLow); // R8

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (!xferActive && regRdData[3] && !waitActive) |-> !sclPullLow); // R8

  AST_RELEASE_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (waitActive && regRdData[2]) |=> !waitActive); // R5

  AST_NO_IRQ_IN_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (waitActive && $past(waitActive)) |-> !irqPulse); // R7

  AST_ERR_SET: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && i2cMode && !regWrData[1]) |=> cfgError); // R10

  AST_ERR_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[1]) |=> !cfgError); // R10

endmodule

bind scl_wait_ctrl scl_wait_ctrl_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regWrData (regWrData),
  .regRdData (regRdData),
  .i2cMode   (i2cMode),
  .xferActive(xferActive),
  .sclPullLow(sclPullLow),
  .irqPulse  (irqPulse),
  .cfgError  (cfgError),
  .waitActive(waitActive)
);

// File: tb/sim_scl_wait_ctrl.sv
`timescale 1ns/1ps
module sim_scl_wait_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       i2cMode = 1'b0;
  logic       xferActive = 1'b0;
  logic       sclIn = 1'b0;
  logic       sclPullLow;
  logic       irqPulse;
  logic       cfgError;

  int checks = 0;
  int errors = 0;
  int irqCnt = 0;
  int lastIrqIdx = 0;
  int pulseIdx = 0;
  int dblIrq = 0;
  logic irqPrev = 1'b0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  scl_wait_ctrl u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .i2cMode(i2cMode), .xferActive(xferActive),
    .sclIn(sclIn), .sclPullLow(sclPullLow), .irqPulse(irqPulse),
    .cfgError(cfgError)
  );

  // interrupt monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (irqPulse) begin
        irqCnt++;
        lastIrqIdx = pulseIdx;
        if (irqPrev) dblIrq++;
      end
      irqPrev = irqPulse;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic wrReg(input logic [7:0] v);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  task automatic sclPulse();
    pulseIdx++;
    sclIn = 1'b1;
    repeat (4) @(negedge clk);
    sclIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 readback", regRdData, 0);
    chk("R1 irq", irqPulse, 0);
    chk("R1 err", cfgError, 0);
    chk("R1 idle pull", sclPullLow, 1);

    // R9 level bit read-only
    wrReg(8'h10);
    chk("R9 write ignored", regRdData[4], 0);
    sclIn = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 level high", regRdData[4], 1);
    wrReg(8'h00);
    chk("R9 level after write 0", regRdData[4], 1);
    sclIn = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 level low", regRdData[4], 0);

    // R8 idle level
    wrReg(8'h08);
    chk("R8 idle released", sclPullLow, 0);
    wrReg(8'h00);
    chk("R8 idle low", sclPullLow, 1);

    // R10 error flag sweep
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        i2cMode = m[0];
        wrReg(8'h08 | 8'(s));
        chk("R10 cfgError", cfgError, (m == 1 && s < 2) ? 1 : 0);
        chk("R10 readback bit5", regRdData[5], (m == 1 && s < 2) ? 1 : 0);
      end
    end
    i2cMode = 1'b0;

    // R2/R3/R4/R5/R6/R7 sweep over all selectors
    for (int s = 0; s < 4; s++) begin
      int hit;
      int hold;
      hit  = (s == 3) ? 9 : 8;
      hold = (s >= 2) ? 1 : 0;
      wrReg(8'h08 | 8'(s));
      xferActive = 1'b1;
      @(negedge clk);
      irqCnt = 0;
      pulseIdx = 0;
      lastIrqIdx = 0;
      for (int p = 0; p < hit; p++) sclPulse();
      chk(hold ? "R2 irq count" : "R4 irq count", irqCnt, 1);
      chk(hold ? "R2 irq edge" : "R4 irq edge", lastIrqIdx, hit);
      chk(hold ? "R3 held" : "R4 not held", sclPullLow, hold);
      if (hold == 1) begin
        xferActive = 1'b0;
        @(negedge clk);
        chk("R3 held without transfer", sclPullLow, 1);
        xferActive = 1'b1;
        for (int p = 0; p < 3; p++) sclPulse();
        chk("R7 no irq in wait", irqCnt, 1);
        chk("R7 still held", sclPullLow, 1);
        wrReg(8'h0C | 8'(s));
        repeat (2) @(negedge clk);
        chk("R5 released", sclPullLow, 0);
        chk("R5 self cleared", regRdData[2], 0);
        pulseIdx = 0;
        for (int p = 0; p < hit - 1; p++) sclPulse();
        chk("R6 no early irq", irqCnt, 1);
        sclPulse();
        chk("R6 irq after full count", irqCnt, 2);
        chk("R6 irq edge", lastIrqIdx, hit);
        wrReg(8'h0C | 8'(s));
        repeat (2) @(negedge clk);
        chk("R5 second release", sclPullLow, 0);
      end else begin
        pulseIdx = 0;
        for (int p = 0; p < hit; p++) sclPulse();
        chk("R4 wrap irq count", irqCnt, 2);
        chk("R4 wrap irq edge", lastIrqIdx, hit);
      end
      xferActive = 1'b0;
      repeat (2) @(negedge clk);
    end

    chk("R11 no double irq", dblIrq, 0);
    done = 1;
    finishRun();
  end

endmodule